// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 16-bit pointers for external data moves and a small control register that picks which of them is active. The active pointer drives the external data address at all times, so a data move that goes through a pointer sees that pointer's current value in the same cycle. Software reads and writes every pointer byte and the control register through a narrow register port: an address, a write strobe, write data and a read-data output that follows the address with no clock in between.

The core signals two kinds of events. The first is a data move that used the active pointer. The second is an explicit pointer-increment instruction. After a data move, the unit can step the pointer that was just used up or down. Each pointer has its own direction. The unit can also invert the active-pointer select, so that a block copy alternates between source and destination with no extra instructions. All of these changes take effect on the clock edge that ends the event's cycle.

Top module: `dptr_pair_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both pointers are cleared to 0000h and every control bit is cleared. As a result, `xaddr` and every register read return 0 afterwards.
- R2: `xaddr` carries the first pointer when control bit 0 (select) is 0 and the second pointer when it is 1. It follows the register contents in the same cycle.
- R3: The register addresses are fixed. Address 0 is the first pointer's low byte, 1 its high byte, 2 the second pointer's low byte, 3 its high byte and 4 the control byte. The control bits are: bit 0 select, bit 2 auto-step enable, bit 3 first-pointer direction, bit 4 second-pointer direction and bit 5 auto-toggle enable. The other control bits read 0. Addresses 5 to 7 read 0 and ignore writes.
- R4: On a data move with auto-step enabled, the active pointer steps by one at the next edge: up when its direction bit is 0, down when it is 1. The inactive pointer is unchanged. With auto-step disabled, a data move leaves both pointers unchanged.
- R5: Stepping wraps. FFFFh steps up to 0000h, and 0000h steps down to FFFFh.
- R6: On a data move with auto-toggle enabled, the select bit inverts at the next edge. Any auto-step in that cycle is applied to the pointer that was active during the move.
- R7: A pointer-increment strobe adds one to the active pointer, whatever the direction and auto-step bits say. It never changes the select bit.
- R8: When the pointer-increment and data-move strobes arrive in the same cycle, only the increment takes effect. There is no data-move step and no toggle.
- R9: A register write takes priority over an automatic change in the same cycle. A write to a byte of the pointer that would step sets that byte, leaves its other byte at the old value, and cancels the step. A write to the control byte replaces the whole control byte, including any toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| mov_use | input | 1 | A data move used the active pointer this cycle |
| ptr_inc | input | 1 | Explicit pointer-increment instruction this cycle |
| xaddr | output | 16 | Active pointer value, the external data address |

## Verification
`xaddr` and `reg_rdata` are combinational views of the stored state. Every strobe changes that state at the rising edge that closes its cycle, so its result is due one edge after the stimulus and never later. The bench drives each cycle's inputs just after a falling edge. It compares both outputs against its model shortly before the next rising edge, and it advances the model at that edge. Each comparison therefore sees all the stimulus up to the previous cycle and none of the stimulus in the current one.

// File: rtl/dptr_pkg.sv
// Package: shared control-byte layout and helpers for the dual data pointer unit.
// Assumes a control byte of 8 bits whose bit positions are fixed by the register map.
package dptr_pkg;

    localparam int CTRL_W    = 8;
    localparam int SEL_BIT   = 0;
    localparam int AUTO_BIT  = 2;
    localparam int DIR0_BIT  = 3;
    localparam int DIR1_BIT  = 4;
    localparam int TGL_BIT   = 5;
    localparam logic [CTRL_W-1:0] CTRL_MASK =
        CTRL_W'((1 << SEL_BIT) | (1 << AUTO_BIT) | (1 << DIR0_BIT) |
                (1 << DIR1_BIT) | (1 << TGL_BIT));

    // Decoded control fields.
    typedef struct packed {
        logic tgl;
        logic dir1;
        logic dir0;
        logic auto_en;
        logic sel;
    } dp_ctrl_t;

    // Unpack a written control byte into fields.
    function automatic dp_ctrl_t ctrl_from_byte(input logic [CTRL_W-1:0] b);
        dp_ctrl_t c;
        c.sel     = b[SEL_BIT];
        c.auto_en = b[AUTO_BIT];
        c.dir0    = b[DIR0_BIT];
        c.dir1    = b[DIR1_BIT];
        c.tgl     = b[TGL_BIT];
        return c;
    endfunction

    // Pack fields back into the byte seen by register reads.
    function automatic logic [CTRL_W-1:0] ctrl_to_byte(input dp_ctrl_t c);
        logic [CTRL_W-1:0] b;
        b           = '0;
        b[SEL_BIT]  = c.sel;
        b[AUTO_BIT] = c.auto_en;
        b[DIR0_BIT] = c.dir0;
        b[DIR1_BIT] = c.dir1;
        b[TGL_BIT]  = c.tgl;
        return b;
    endfunction

endpackage

// File: rtl/dptr_slot.sv
// One data pointer: byte-lane writes from software, and a +/-1 step requested by the
// unit's control logic. A write to any lane wins over a step in the same cycle. The
// lanes that are not written keep their old value. Assumes PTR_W is a multiple of LANE_W.
module dptr_slot #(
    parameter int PTR_W  = 16,
    parameter int LANE_W = 8,
    localparam int LANES = PTR_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [LANE_W-1:0] lane_wdata,
    input  logic              step_en,
    input  logic              step_down,
    output logic [PTR_W-1:0]  value
);

    logic [PTR_W-1:0] written;
    logic [PTR_W-1:0] stepped;
    logic [PTR_W-1:0] nxt;

    // Merge written lanes into the current value.
    always_comb begin
        written = value;
        for (int j = 0; j < LANES; j++) begin
            if (lane_we[j]) begin
                written[j*LANE_W +: LANE_W] = lane_wdata;
            end
        end
    end

    // Step by one in the requested direction, wrapping at both ends.
    always_comb begin
        stepped = step_down ? (value - PTR_W'(1)) : (value + PTR_W'(1));
    end

    // Choose the next value: a write first, then a step, else hold.
    always_comb begin
        if (|lane_we) begin
            nxt = written;
        end else if (step_en) begin
            nxt = stepped;
        end else begin
            nxt = value;
        end
    end

    // Pointer storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= nxt;
        end
    end

    // R4 / R5: an unobstructed step moves the pointer by exactly one, modulo 2^PTR_W.
    a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !(|lane_we)) |=>
            (value == ($past(step_down) ? ($past(value) - PTR_W'(1))
                                        : ($past(value) + PTR_W'(1)))));

    // R4: with no write and no step, the pointer holds.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !(|lane_we)) |=> $stable(value));

    // R9: a written lane takes the written byte, even when a step was requested.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            lane_we[g] |=> (value[g*LANE_W +: LANE_W] == $past(lane_wdata)));
    end

endmodule

// File: rtl/dptr_ctrl.sv
// Control register for the pointer pair: select, auto-step enable, per-pointer
// direction and auto-toggle enable. A register write replaces the whole byte and wins
// over the toggle a data move would cause in the same cycle.
module dptr_ctrl
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              move_fire,
    output dp_ctrl_t          ctrl
);

    dp_ctrl_t nxt;

    // Next control state: a write first, then an auto-toggle on a data move.
    always_comb begin
        nxt = ctrl;
        if (ctrl_we) begin
            nxt = ctrl_from_byte(ctrl_wdata);
        end else if (move_fire && ctrl.tgl) begin
            nxt.sel = ~ctrl.sel;
        end
    end

    // Control storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            ctrl <= nxt;
        end
    end

    // R6: a data move with toggle enabled and no register write inverts the select.
    a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (move_fire && ctrl.tgl && !ctrl_we) |=> (ctrl.sel != $past(ctrl.sel)));

    // R6: with no write and no qualifying data move, the control byte holds.
    a_r6_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !move_fire) |=> $stable(ctrl));

    // R9 / R3: a write lands as the masked byte, whatever the data move did.
    a_r9_ctrl_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_to_byte(ctrl) == ($past(ctrl_wdata) & CTRL_MASK)));

endmodule

// File: rtl/dptr_regmux.sv
// Read-back multiplexer: returns the pointer byte or control byte at the given address,
// and zero for unmapped addresses. Assumes pointer lanes come first, ordered by pointer
// then by lane, followed by the control byte.
module dptr_regmux #(
    parameter int PTR_W  = 16,
    parameter int LANE_W = 8,
    parameter int REG_AW = 3,
    localparam int LANES = PTR_W / LANE_W,
    localparam int NPTR_LANES = 2 * LANES
) (
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [2*PTR_W-1:0]  ptr_flat,
    input  logic [LANE_W-1:0]   ctrl_byte,
    output logic [LANE_W-1:0]   reg_rdata
);

    // Select the addressed byte; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NPTR_LANES; i++) begin
            if (reg_addr == REG_AW'(i)) begin
                reg_rdata = ptr_flat[i*LANE_W +: LANE_W];
            end
        end
        if (reg_addr == REG_AW'(NPTR_LANES)) begin
            reg_rdata = ctrl_byte;
        end
    end

endmodule

// File: rtl/dptr_pair_unit.sv
// Dual data pointer unit: two pointers, a control register, and the automatic
// step/toggle applied after a data move. An explicit increment strobe overrides a
// simultaneous data move. Assumes LANE_W >= 8, so that the control byte fits one lane.
module dptr_pair_unit
    import dptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int LANE_W = 8,
    localparam int LANES = PTR_W / LANE_W,
    localparam int CTRL_ADDR = 2 * LANES,
    localparam int REG_AW = $clog2(CTRL_ADDR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [LANE_W-1:0] reg_wdata,
    output logic [LANE_W-1:0] reg_rdata,
    input  logic              mov_use,
    input  logic              ptr_inc,
    output logic [PTR_W-1:0]  xaddr
);

    dp_ctrl_t          ctrl;
    logic              move_fire;
    logic              ctrl_we;
    logic [PTR_W-1:0]  ptr_val [2];
    logic [2*PTR_W-1:0] ptr_flat;
    logic [LANE_W-1:0] ctrl_byte;

    // Event qualification: an increment suppresses a simultaneous data move.
    always_comb begin
        move_fire = mov_use && !ptr_inc;
        ctrl_we   = reg_wr && (reg_addr == REG_AW'(CTRL_ADDR));
    end

    dptr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (reg_wdata[CTRL_W-1:0]),
        .move_fire  (move_fire),
        .ctrl       (ctrl)
    );

    for (genvar p = 0; p < 2; p++) begin : g_ptr
        logic [LANES-1:0] lane_we;
        logic             is_active;
        logic             step_en;
        logic             step_down;

        // Lane write decode and step request for this pointer.
        always_comb begin
            for (int j = 0; j < LANES; j++) begin
                lane_we[j] = reg_wr && (reg_addr == REG_AW'(p * LANES + j));
            end
            is_active = (ctrl.sel == p[0]);
            step_en   = is_active && (ptr_inc || (move_fire && ctrl.auto_en));
            step_down = !ptr_inc && ((p == 0) ? ctrl.dir0 : ctrl.dir1);
        end

        dptr_slot #(
            .PTR_W  (PTR_W),
            .LANE_W (LANE_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .lane_we    (lane_we),
            .lane_wdata (reg_wdata),
            .step_en    (step_en),
            .step_down  (step_down),
            .value      (ptr_val[p])
        );
    end

    // Output address and read-back sources.
    always_comb begin
        xaddr     = ctrl.sel ? ptr_val[1] : ptr_val[0];
        ptr_flat  = {ptr_val[1], ptr_val[0]};
        ctrl_byte = LANE_W'(ctrl_to_byte(ctrl));
    end

    dptr_regmux #(
        .PTR_W  (PTR_W),
        .LANE_W (LANE_W),
        .REG_AW (REG_AW)
    ) u_rdmux (
        .reg_addr  (reg_addr),
        .ptr_flat  (ptr_flat),
        .ctrl_byte (ctrl_byte),
        .reg_rdata (reg_rdata)
    );

    // R7: an increment never moves the select.
    a_r7_inc_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !reg_wr) |=> (ctrl.sel == $past(ctrl.sel)));

    // R7 / R8 / R2: with no register write, an increment raises the output address by one.
    a_r8_inc_moves_xaddr: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !reg_wr) |=> (xaddr == $past(xaddr) + PTR_W'(1)));

    // R1: the cycle after reset, the output address is zero.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (xaddr == '0));

endmodule

// File: tb/dptr_pair_unit_tb.sv
// Bench for the dual data pointer unit. A behavioural model is advanced at every rising
// edge, and both outputs are compared against it before each edge.
module dptr_pair_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk;
    logic        rst_n;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        mov_use;
    logic        ptr_inc;
    logic [15:0] xaddr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [15:0] m_ptr [2];
    logic [7:0]  m_ctrl;

    dptr_pair_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mov_use   (mov_use),
        .ptr_inc   (ptr_inc),
        .xaddr     (xaddr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ptr[0][7:0];
            3'd1: return m_ptr[0][15:8];
            3'd2: return m_ptr[1][7:0];
            3'd3: return m_ptr[1][15:8];
            3'd4: return m_ctrl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic [2:0] a, input logic [7:0] d,
                              input logic mv, input logic inc);
        logic [15:0] np [2];
        logic [7:0]  nc;
        int s;
        np = m_ptr;
        nc = m_ctrl;
        s = int'(m_ctrl[0]);
        if (inc) begin
            np[s] = m_ptr[s] + 16'd1;
        end else if (mv) begin
            if (m_ctrl[2]) np[s] = m_ctrl[3 + s] ? m_ptr[s] - 16'd1 : m_ptr[s] + 16'd1;
            if (m_ctrl[5]) nc[0] = ~m_ctrl[0];
        end
        if (wr) begin
            if (a < 3'd4) begin
                np[a / 2] = m_ptr[a / 2];
                if (a[0]) np[a / 2][15:8] = d;
                else      np[a / 2][7:0]  = d;
            end else if (a == 3'd4) begin
                nc = d & 8'h3D;
            end
        end
        m_ptr = np;
        m_ctrl = nc;
    endtask

    // One cycle: drive after the falling edge, compare before the rising edge, then advance the model.
    task automatic apply(input logic wr, input logic [2:0] a, input logic [7:0] d,
                         input logic mv, input logic inc, input string tag);
        reg_wr = wr; reg_addr = a; reg_wdata = d; mov_use = mv; ptr_inc = inc;
        #1;
        check({tag, " xaddr"}, xaddr, m_ctrl[0] ? m_ptr[1] : m_ptr[0]);
        check({tag, " rdata"}, {8'h00, reg_rdata}, {8'h00, model_read(a)});
        @(posedge clk);
        model_step(wr, a, d, mv, inc);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string tag);
        apply(1'b1, a, d, 1'b0, 1'b0, tag);
    endtask

    task automatic mov(input string tag);
        apply(1'b0, 3'd4, 8'h00, 1'b1, 1'b0, tag);
    endtask

    // Read a register and compare it to a fixed value from the requirements.
    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        reg_wr = 1'b0; reg_addr = a; mov_use = 1'b0; ptr_inc = 1'b0;
        #1;
        check({tag, " fixed"}, {8'h00, reg_rdata}, {8'h00, exp});
        apply(1'b0, a, 8'h00, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
        mov_use = 1'b0; ptr_inc = 1'b0;
        m_ptr[0] = 16'h0000; m_ptr[1] = 16'h0000; m_ctrl = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        check("R1 xaddr", xaddr, 16'h0000);
        for (int a = 0; a < 5; a++) peek(3'(a), 8'h00, "R1");

        // R3: byte map, masked control, unmapped address.
        wr_reg(3'd0, 8'h34, "R3"); wr_reg(3'd1, 8'h12, "R3");
        wr_reg(3'd2, 8'hCD, "R3"); wr_reg(3'd3, 8'hAB, "R3");
        peek(3'd0, 8'h34, "R3"); peek(3'd1, 8'h12, "R3");
        peek(3'd2, 8'hCD, "R3"); peek(3'd3, 8'hAB, "R3");
        check("R2 select0", xaddr, 16'h1234);
        wr_reg(3'd4, 8'h01, "R2");
        check("R2 select1", xaddr, 16'hABCD);
        wr_reg(3'd4, 8'hFF, "R3");
        peek(3'd4, 8'h3D, "R3");
        wr_reg(3'd5, 8'h55, "R3");
        peek(3'd5, 8'h00, "R3");
        peek(3'd0, 8'h34, "R3");

        // R4: direction per pointer; auto-step disabled.
        wr_reg(3'd4, 8'h04, "R4");
        mov("R4");
        check("R4 up", xaddr, 16'h1235);
        wr_reg(3'd4, 8'h0C, "R4");
        mov("R4"); mov("R4");
        check("R4 down", xaddr, 16'h1233);
        wr_reg(3'd4, 8'h15, "R4");
        mov("R4");
        check("R4 ptr1 down", xaddr, 16'hABCC);
        peek(3'd0, 8'h33, "R4");
        wr_reg(3'd4, 8'h00, "R4");
        mov("R4");
        check("R4 disabled", xaddr, 16'h1233);

        // R5: wrap in both directions.
        wr_reg(3'd0, 8'hFF, "R5"); wr_reg(3'd1, 8'hFF, "R5");
        wr_reg(3'd4, 8'h04, "R5");
        mov("R5");
        check("R5 up wrap", xaddr, 16'h0000);
        wr_reg(3'd4, 8'h0C, "R5");
        mov("R5");
        check("R5 down wrap", xaddr, 16'hFFFF);
        apply(1'b0, 3'd4, 8'h00, 1'b0, 1'b1, "R7");
        check("R7 inc wrap", xaddr, 16'h0000);

        // R6: toggle after the step of the pointer that was used.
        wr_reg(3'd0, 8'h10, "R6"); wr_reg(3'd1, 8'h00, "R6");
        wr_reg(3'd2, 8'h00, "R6"); wr_reg(3'd3, 8'h02, "R6");
        wr_reg(3'd4, 8'h24, "R6");
        mov("R6");
        check("R6 flipped to ptr1", xaddr, 16'h0200);
        peek(3'd0, 8'h11, "R6");
        mov("R6");
        check("R6 back to ptr0", xaddr, 16'h0011);
        peek(3'd2, 8'h01, "R6");
        wr_reg(3'd4, 8'h20, "R6");
        mov("R6");
        check("R6 toggle only", xaddr, 16'h0201);

        // R7 / R8: increment ignores direction, never toggles, overrides a data move.
        wr_reg(3'd4, 8'h3D, "R7");
        apply(1'b0, 3'd4, 8'h00, 1'b0, 1'b1, "R7");
        check("R7 inc", xaddr, 16'h0202);
        peek(3'd4, 8'h3D, "R7");
        apply(1'b0, 3'd4, 8'h00, 1'b1, 1'b1, "R8");
        check("R8 inc only", xaddr, 16'h0203);
        peek(3'd4, 8'h3D, "R8");

        // R9: register writes win over automatic changes.
        wr_reg(3'd4, 8'h04, "R9");
        apply(1'b1, 3'd0, 8'h77, 1'b1, 1'b0, "R9");
        check("R9 ptr write wins", xaddr, 16'h0077);
        apply(1'b1, 3'd3, 8'h5A, 1'b1, 1'b0, "R9");
        check("R9 other ptr steps", xaddr, 16'h0078);
        wr_reg(3'd4, 8'h24, "R9");
        apply(1'b1, 3'd4, 8'h00, 1'b1, 1'b0, "R9");
        peek(3'd4, 8'h00, "R9");

        // Mixed traffic against the model (R4 R6 R7 R8 R9).
        for (int n = 0; n < 600; n++) begin
            logic w, m, i;
            w = ($urandom % 4) == 0;
            m = ($urandom % 2) == 0;
            i = ($urandom % 8) == 0;
            apply(w, 3'($urandom % 6), 8'($urandom), m, i, "R9 mix");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule